// File: doc/BRIEF.md
# Multi-core reset and boot controller

This block sits on a 32-bit register bus and governs reset and power-up of a four-core processor cluster. Software writes a control word whose bits enable or disable the three secondary cores, request a reset of any of the four cores, or request a software reset of two display units. Each core owns a request/acknowledge channel toward the core power and boot logic. A start request carries the entry address and argument that software has placed beforehand in a dedicated pair of general-purpose registers.

Only bits that change on a control write cause an action. A per-core reset bit stays set until the addressed core acknowledges its request, and then clears by itself. The display reset bits finish at once and never read back as set. The other registers are plain storage. The register window is 4 KiB. Accesses outside the fifteen implemented words, and accesses that are not word aligned, are refused, and a one-cycle error pulse reports them.

Top module: `core_rst_ctrl`

## Requirements
- R1: After reset, word 0 (control) reads 0x521, word 3 (reset status) reads 0x1, word 4 (interrupt mask) reads 0x1F, and every other word reads 0. No core request is raised.
- R2: The word index is `acc_addr[11:2]`. Words 1 to 14 store a written value unchanged, and writing them raises no core request. Read data appears on `rd_data` one cycle after the read and is held until the next read.
- R3: An access with index 15 or above, or with `acc_addr[1:0]` nonzero, raises `acc_err` for exactly the following cycle. Such a read returns 0 and such a write changes no register.
- R4: A rising enable bit for core n (control bit 21+n, n = 1..3) queues a request with op 2'b01 (start) to core n. The request's address is word 5+2n and its argument is word 6+2n, taken at the time of the write.
- R5: A falling enable bit for core n queues a request with op 2'b10 (stop) to core n, with address and argument 0.
- R6: When core n's enable bit changes, core n's reset bit (control bit 13+n) is stored as written and raises no reset request of its own. It clears when core n acknowledges.
- R7: When the reset bit of core c (control bit 13+c, c = 0..3) changes and that core's enable bit does not, a request with op 2'b11 (reset) is queued to core c. Every acknowledge from core c clears that bit, and the clear takes priority over a control write made in the same cycle.
- R8: Display reset bits 3 and 12 of the control word are stored as 0 on any write that changes them.
- R9: A control write that changes no action bit queues no request.
- R10: While `core_req[c]` is high and `core_ack[c]` is low, the op, address and argument of core c stay stable. Requests to one core are served in order. A request that arrives when QUEUE_DEPTH requests are already pending, with no acknowledge in that cycle, is dropped. Op, address and argument read 0 while no request is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Register access strobe, one access per cycle |
| acc_we | input | 1 | 1 for a write, 0 for a read |
| acc_addr | input | 12 | Byte offset inside the window |
| acc_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, registered |
| acc_err | output | 1 | One-cycle pulse for a refused access |
| core_req | output | 4 | Per-core pending request |
| core_op | output | 8 | Per-core op code, 2 bits per core |
| core_addr | output | 128 | Per-core entry address, 32 bits per core |
| core_arg | output | 128 | Per-core argument, 32 bits per core |
| core_ack | input | 4 | Per-core acknowledge of the pending request |

## Verification
The bench enables a core together with a change to its reset bit. A design that handled the bit twice would send a second reset request behind the start. It toggles a reset bit repeatedly without acknowledging, so that a wrong queue would reorder the requests, lose them or overflow silently. It acknowledges in the same cycle as a control write that rewrites the reset bit as 1, and a design that let the write win would leave the bit stuck high. It also writes the display bits, rewrites the control word unchanged, and reads and writes misaligned and out-of-range offsets. These catch reset bits that never read back as cleared, spurious requests, and corrupted registers or a missing error pulse.

// File: rtl/rstc_pkg.sv
`timescale 1ns/1ps
package rstc_pkg;
    localparam int DATA_W    = 32;
    localparam int NUM_CORES = 4;
    localparam int REG_COUNT = 15;
    localparam int IDX_W     = $clog2(REG_COUNT);
    localparam int ADDR_W    = 12;
    localparam int OP_W      = 2;

    localparam int CTRL_IDX  = 0;
    localparam int GPR_BASE  = 5;
    localparam int RST_BASE  = 13;
    localparam int EN_BASE   = 22;
    localparam int DISP1_BIT = 3;
    localparam int DISP2_BIT = 12;

    typedef enum logic [OP_W-1:0] {
        OP_NONE  = 2'b00,
        OP_START = 2'b01,
        OP_STOP  = 2'b10,
        OP_RESET = 2'b11
    } core_op_e;

    typedef struct packed {
        core_op_e          op;
        logic [DATA_W-1:0] addr;
        logic [DATA_W-1:0] arg;
    } core_cmd_t;

    function automatic logic [DATA_W-1:0] reg_reset_value(int idx);
        case (idx)
            0:       return 32'h0000_0521;
            3:       return 32'h0000_0001;
            4:       return 32'h0000_001F;
            default: return '0;
        endcase
    endfunction

    function automatic int entry_word(int core);
        return GPR_BASE + 2 * core;
    endfunction

    function automatic int param_word(int core);
        return GPR_BASE + 2 * core + 1;
    endfunction
endpackage

// File: rtl/rstc_req_queue.sv
`timescale 1ns/1ps
module rstc_req_queue
    import rstc_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      push,
    input  core_cmd_t push_cmd,
    input  logic      pop,
    output logic      valid,
    output core_cmd_t head
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    core_cmd_t        slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             accept, take;

    function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign valid  = (count != '0);
    assign take   = pop && valid;
    assign accept = push && ((count != CNT_W'(DEPTH)) || take);
    assign head   = valid ? slots[rd_ptr] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
        end else begin
            if (accept) begin
                slots[wr_ptr] <= push_cmd;
                wr_ptr        <= bump(wr_ptr);
            end
            if (take) rd_ptr <= bump(rd_ptr);
            case ({accept, take})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/rstc_ctrl_next.sv
`timescale 1ns/1ps
module rstc_ctrl_next
    import rstc_pkg::*;
(
    input  logic [DATA_W-1:0] ctrl_old,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_ctrl,
    input  logic [DATA_W-1:0] entry_addr [NUM_CORES],
    input  logic [DATA_W-1:0] entry_arg  [NUM_CORES],
    output logic [DATA_W-1:0] ctrl_new,
    output logic              push       [NUM_CORES],
    output core_cmd_t         push_cmd   [NUM_CORES]
);
    logic [DATA_W-1:0] diff;
    assign diff = ctrl_old ^ wdata;

    always_comb begin
        ctrl_new = wdata;
        if (diff[DISP1_BIT]) ctrl_new[DISP1_BIT] = 1'b0;
        if (diff[DISP2_BIT]) ctrl_new[DISP2_BIT] = 1'b0;
    end

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        logic en_diff, en_val;
        if (c == 0) begin : g_boot
            assign en_diff = 1'b0;
            assign en_val  = 1'b0;
        end else begin : g_sec
            assign en_diff = diff[EN_BASE + c - 1];
            assign en_val  = wdata[EN_BASE + c - 1];
        end

        always_comb begin
            push[c]     = wr_ctrl && (en_diff || diff[RST_BASE + c]);
            push_cmd[c] = '0;
            if (en_diff) begin
                if (en_val) begin
                    push_cmd[c].op   = OP_START;
                    push_cmd[c].addr = entry_addr[c];
                    push_cmd[c].arg  = entry_arg[c];
                end else begin
                    push_cmd[c].op = OP_STOP;
                end
            end else begin
                push_cmd[c].op = OP_RESET;
            end
        end
    end
endmodule

// File: rtl/core_rst_ctrl.sv
`timescale 1ns/1ps
module core_rst_ctrl
    import rstc_pkg::*;
#(
    parameter int QUEUE_DEPTH = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        acc_en,
    input  logic                        acc_we,
    input  logic [ADDR_W-1:0]           acc_addr,
    input  logic [DATA_W-1:0]           acc_wdata,
    output logic [DATA_W-1:0]           rd_data,
    output logic                        acc_err,
    output logic [NUM_CORES-1:0]        core_req,
    output logic [NUM_CORES*OP_W-1:0]   core_op,
    output logic [NUM_CORES*DATA_W-1:0] core_addr,
    output logic [NUM_CORES*DATA_W-1:0] core_arg,
    input  logic [NUM_CORES-1:0]        core_ack
);
    localparam int WIDX_W = ADDR_W - 2;

    logic [DATA_W-1:0] regs_q [REG_COUNT];
    logic [DATA_W-1:0] regs_d [REG_COUNT];
    logic [DATA_W-1:0] rd_q;
    logic              err_q;

    logic [WIDX_W-1:0] widx;
    logic [IDX_W-1:0]  sidx;
    logic              hit, wr_hit, wr_ctrl;

    assign widx    = acc_addr[ADDR_W-1:2];
    assign sidx    = widx[IDX_W-1:0];
    assign hit     = (widx < WIDX_W'(REG_COUNT)) && (acc_addr[1:0] == 2'b00);
    assign wr_hit  = acc_en && acc_we && hit;
    assign wr_ctrl = wr_hit && (sidx == IDX_W'(CTRL_IDX));

    logic [DATA_W-1:0] entry_addr [NUM_CORES];
    logic [DATA_W-1:0] entry_arg  [NUM_CORES];
    logic [DATA_W-1:0] ctrl_new;
    logic              push       [NUM_CORES];
    core_cmd_t         push_cmd   [NUM_CORES];
    logic [DATA_W-1:0] ack_clear;

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_src
        if (c == 0) begin : g_none
            assign entry_addr[c] = '0;
            assign entry_arg[c]  = '0;
        end else begin : g_gpr
            assign entry_addr[c] = regs_q[entry_word(c)];
            assign entry_arg[c]  = regs_q[param_word(c)];
        end
    end

    rstc_ctrl_next u_next (
        .ctrl_old   (regs_q[CTRL_IDX]),
        .wdata      (acc_wdata),
        .wr_ctrl    (wr_ctrl),
        .entry_addr (entry_addr),
        .entry_arg  (entry_arg),
        .ctrl_new   (ctrl_new),
        .push       (push),
        .push_cmd   (push_cmd)
    );

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_chan
        core_cmd_t head;
        logic      pop;
        assign pop = core_ack[c] && core_req[c];

        rstc_req_queue #(.DEPTH(QUEUE_DEPTH)) u_queue (
            .clk      (clk),
            .rst      (rst),
            .push     (push[c]),
            .push_cmd (push_cmd[c]),
            .pop      (pop),
            .valid    (core_req[c]),
            .head     (head)
        );

        assign core_op  [c*OP_W   +: OP_W]   = head.op;
        assign core_addr[c*DATA_W +: DATA_W] = head.addr;
        assign core_arg [c*DATA_W +: DATA_W] = head.arg;
    end

    always_comb begin
        ack_clear = '0;
        for (int c = 0; c < NUM_CORES; c++)
            ack_clear[RST_BASE + c] = core_ack[c] && core_req[c];
    end

    always_comb begin
        for (int i = 0; i < REG_COUNT; i++) regs_d[i] = regs_q[i];
        if (wr_hit && !wr_ctrl) regs_d[sidx] = acc_wdata;
        regs_d[CTRL_IDX] = (wr_ctrl ? ctrl_new : regs_q[CTRL_IDX]) & ~ack_clear;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < REG_COUNT; i++) regs_q[i] <= reg_reset_value(i);
            rd_q  <= '0;
            err_q <= 1'b0;
        end else begin
            for (int i = 0; i < REG_COUNT; i++) regs_q[i] <= regs_d[i];
            err_q <= acc_en && !hit;
            if (acc_en && !acc_we) rd_q <= hit ? regs_q[sidx] : '0;
        end
    end

    assign rd_data = rd_q;
    assign acc_err = err_q;
endmodule

// File: rtl/rstc_checker.sv
`timescale 1ns/1ps
module rstc_checker
    import rstc_pkg::*;
(
    input logic                        clk,
    input logic                        rst,
    input logic                        acc_en,
    input logic [ADDR_W-1:0]           acc_addr,
    input logic                        acc_err,
    input logic [NUM_CORES-1:0]        core_req,
    input logic [NUM_CORES*OP_W-1:0]   core_op,
    input logic [NUM_CORES*DATA_W-1:0] core_addr,
    input logic [NUM_CORES*DATA_W-1:0] core_arg,
    input logic [NUM_CORES-1:0]        core_ack,
    input logic [DATA_W-1:0]           ctrl_q
);
    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ctrl_q == 32'h0000_0521) && (core_req == '0));

    a_r3_err_pulse: assert property (@(posedge clk) disable iff (rst)
        acc_err |-> $past(acc_en) &&
                    (($past(acc_addr[ADDR_W-1:2]) >= (ADDR_W-2)'(REG_COUNT)) ||
                     ($past(acc_addr[1:0]) != 2'b00)));

    a_r8_display_clear: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q[DISP1_BIT] && !ctrl_q[DISP2_BIT]);

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_chk
        a_r10_hold: assert property (@(posedge clk) disable iff (rst)
            core_req[c] && !core_ack[c] |=> core_req[c] &&
                $stable(core_op[c*OP_W +: OP_W]) &&
                $stable(core_addr[c*DATA_W +: DATA_W]) &&
                $stable(core_arg[c*DATA_W +: DATA_W]));

        a_r7_ack_clears: assert property (@(posedge clk) disable iff (rst)
            core_req[c] && core_ack[c] |=> !ctrl_q[RST_BASE + c]);

        a_r10_idle_zero: assert property (@(posedge clk) disable iff (rst)
            !core_req[c] |-> (core_op[c*OP_W +: OP_W] == '0) &&
                             (core_addr[c*DATA_W +: DATA_W] == '0));
    end
endmodule

bind core_rst_ctrl rstc_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .acc_en    (acc_en),
    .acc_addr  (acc_addr),
    .acc_err   (acc_err),
    .core_req  (core_req),
    .core_op   (core_op),
    .core_addr (core_addr),
    .core_arg  (core_arg),
    .core_ack  (core_ack),
    .ctrl_q    (regs_q[0])
);

// File: tb/tb_core_rst_ctrl.sv
`timescale 1ns/1ps
module tb_core_rst_ctrl;
    localparam int QD = 4;
    localparam int WD = 20000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         acc_en = 1'b0, acc_we = 1'b0;
    logic [11:0]  acc_addr = '0;
    logic [31:0]  acc_wdata = '0;
    logic [31:0]  rd_data;
    logic         acc_err;
    logic [3:0]   core_req;
    logic [7:0]   core_op;
    logic [127:0] core_addr, core_arg;
    logic [3:0]   core_ack = '0;

    always #2.5 clk = ~clk;

    core_rst_ctrl #(.QUEUE_DEPTH(QD)) dut (
        .clk(clk), .rst(rst), .acc_en(acc_en), .acc_we(acc_we),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rd_data(rd_data),
        .acc_err(acc_err), .core_req(core_req), .core_op(core_op),
        .core_addr(core_addr), .core_arg(core_arg), .core_ack(core_ack)
    );

    int    checks = 0, fails = 0;
    string tag = "R1";

    // behavioural reference
    logic [31:0] m_regs [15];
    logic [1:0]  m_op   [4][QD];
    logic [31:0] m_addr [4][QD];
    logic [31:0] m_arg  [4][QD];
    int          m_cnt  [4];
    logic [31:0] m_rd;
    logic        m_err;

    task automatic m_push(int c, logic [1:0] op, logic [31:0] a, logic [31:0] g);
        if (m_cnt[c] < QD) begin
            m_op[c][m_cnt[c]] = op; m_addr[c][m_cnt[c]] = a; m_arg[c][m_cnt[c]] = g;
            m_cnt[c]++;
        end
    endtask

    task automatic m_update();
        int  idx;
        bit  ok;
        logic [31:0] old, nv, dif;
        bit  clr [4];
        if (rst) begin
            for (int i = 0; i < 15; i++) m_regs[i] = 0;
            m_regs[0] = 32'h521; m_regs[3] = 32'h1; m_regs[4] = 32'h1F;
            for (int c = 0; c < 4; c++) m_cnt[c] = 0;
            m_rd = 0; m_err = 0;
            return;
        end
        idx = int'(acc_addr >> 2);
        ok  = (idx < 15) && (acc_addr[1:0] == 0);
        m_err = acc_en && !ok;
        if (acc_en && !acc_we) m_rd = ok ? m_regs[idx] : 0;
        for (int c = 0; c < 4; c++) begin
            clr[c] = core_ack[c] && (m_cnt[c] > 0);
            if (clr[c]) begin
                for (int k = 0; k < QD - 1; k++) begin
                    m_op[c][k] = m_op[c][k+1]; m_addr[c][k] = m_addr[c][k+1];
                    m_arg[c][k] = m_arg[c][k+1];
                end
                m_cnt[c]--;
            end
        end
        if (acc_en && acc_we && ok) begin
            if (idx == 0) begin
                old = m_regs[0]; nv = acc_wdata; dif = old ^ nv;
                for (int c = 0; c < 4; c++) begin
                    if (c > 0 && dif[21+c]) begin
                        if (nv[21+c]) m_push(c, 2'b01, m_regs[5+2*c], m_regs[6+2*c]);
                        else          m_push(c, 2'b10, 0, 0);
                    end else if (dif[13+c]) m_push(c, 2'b11, 0, 0);
                end
                if (dif[3])  nv[3]  = 1'b0;
                if (dif[12]) nv[12] = 1'b0;
                m_regs[0] = nv;
            end else m_regs[idx] = acc_wdata;
        end
        for (int c = 0; c < 4; c++) if (clr[c]) m_regs[0][13+c] = 1'b0;
    endtask

    task automatic compare();
        bit bad = 0;
        checks++;
        if (rd_data !== m_rd || acc_err !== m_err) bad = 1;
        for (int c = 0; c < 4; c++) begin
            if (core_req[c] !== (m_cnt[c] > 0)) bad = 1;
            if (core_op[2*c+:2]    !== (m_cnt[c] > 0 ? m_op[c][0]   : 2'b0))  bad = 1;
            if (core_addr[32*c+:32] !== (m_cnt[c] > 0 ? m_addr[c][0] : 32'h0)) bad = 1;
            if (core_arg[32*c+:32]  !== (m_cnt[c] > 0 ? m_arg[c][0]  : 32'h0)) bad = 1;
        end
        if (bad) begin
            fails++;
            $display("FAIL %s cycle compare: rd=%h/%h err=%b/%b req=%b op=%h addr0..3=%h (exp rd=%h err=%b cnt=%0d,%0d,%0d,%0d)",
                     tag, rd_data, m_rd, acc_err, m_err, core_req, core_op, core_addr,
                     m_rd, m_err, m_cnt[0], m_cnt[1], m_cnt[2], m_cnt[3]);
        end
    endtask

    task automatic step();
        @(posedge clk);
        m_update();
        @(negedge clk);
        compare();
        acc_en = 0; acc_we = 0; core_ack = '0;
    endtask

    task automatic chk(bit ok, string t, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", t, act, exp);
        end
    endtask

    task automatic wr(int idx, logic [31:0] d);
        acc_en = 1; acc_we = 1; acc_addr = 12'(idx * 4); acc_wdata = d;
        step();
    endtask

    task automatic rd_expect(int idx, logic [31:0] exp, string t);
        acc_en = 1; acc_we = 0; acc_addr = 12'(idx * 4);
        step();
        chk(rd_data === exp, t, rd_data, exp);
    endtask

    task automatic ack(int c);
        core_ack[c] = 1'b1;
        step();
    endtask

    initial begin
        repeat (WD) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] cv;
        @(negedge clk);
        repeat (3) step();
        rst = 0;
        step();
        tag = "R1";
        chk(core_req === 4'b0, "R1 no request after reset", {28'b0, core_req}, 0);
        rd_expect(0, 32'h521, "R1 control reset value");
        rd_expect(3, 32'h1,   "R1 status reset value");
        rd_expect(4, 32'h1F,  "R1 mask reset value");
        rd_expect(1, 32'h0,   "R1 word1 reset value");
        rd_expect(14, 32'h0,  "R1 word14 reset value");

        tag = "R2";
        for (int i = 5; i <= 12; i++) wr(i, 32'hA000_0000 + 32'(i * 17));
        wr(2, 32'hDEAD_BEEF);
        chk(core_req === 4'b0, "R2 storage write raises no request", {28'b0, core_req}, 0);
        rd_expect(7, 32'hA000_0000 + 32'(7 * 17), "R2 word7 readback");
        rd_expect(2, 32'hDEAD_BEEF, "R2 word2 readback");
        step();
        chk(rd_data === 32'hDEAD_BEEF, "R2 read data held", rd_data, 32'hDEAD_BEEF);

        tag = "R3";
        rd_expect(15, 32'h0, "R3 read beyond last word");
        chk(acc_err === 1'b1, "R3 error on bad read", {31'b0, acc_err}, 1);
        step();
        chk(acc_err === 1'b0, "R3 error lasts one cycle", {31'b0, acc_err}, 0);
        acc_en = 1; acc_we = 1; acc_addr = 12'h7FC; acc_wdata = 32'hFFFF_FFFF; step();
        chk(acc_err === 1'b1, "R3 error on bad write", {31'b0, acc_err}, 1);
        acc_en = 1; acc_we = 1; acc_addr = 12'h009; acc_wdata = 32'h1234_5678; step();
        chk(acc_err === 1'b1, "R3 error on misaligned write", {31'b0, acc_err}, 1);
        rd_expect(2, 32'hDEAD_BEEF, "R3 misaligned write dropped");
        acc_en = 1; acc_we = 0; acc_addr = 12'h00E; step();
        chk(rd_data === 32'h0, "R3 misaligned read returns zero", rd_data, 0);

        tag = "R4";
        wr(0, m_regs[0] | (32'h1 << 22));
        chk(core_req[1] === 1'b1 && core_op[3:2] === 2'b01, "R4 core1 start op",
            {24'b0, core_op}, 32'h04);
        chk(core_addr[63:32] === 32'hA000_0000 + 32'(7 * 17), "R4 core1 entry address",
            core_addr[63:32], 32'hA000_0000 + 32'(7 * 17));
        chk(core_arg[63:32] === 32'hA000_0000 + 32'(8 * 17), "R4 core1 argument",
            core_arg[63:32], 32'hA000_0000 + 32'(8 * 17));
        tag = "R10";
        repeat (3) step();
        chk(core_req[1] === 1'b1 && core_addr[63:32] === 32'hA000_0000 + 32'(7 * 17),
            "R10 start held until ack", core_addr[63:32], 32'hA000_0000 + 32'(7 * 17));
        ack(1);
        chk(core_req[1] === 1'b0, "R10 released after ack", {31'b0, core_req[1]}, 0);

        tag = "R6";
        wr(0, m_regs[0] | (32'h1 << 23) | (32'h1 << 15));
        chk(core_op[5:4] === 2'b01 && core_addr[95:64] === 32'hA000_0000 + 32'(9 * 17),
            "R6 core2 start with word9", core_addr[95:64], 32'hA000_0000 + 32'(9 * 17));
        cv = m_regs[0];
        rd_expect(0, cv, "R6 reset bit held before ack");
        chk(rd_data[15] === 1'b1, "R6 core2 reset bit set", rd_data, cv);
        ack(2);
        chk(core_req[2] === 1'b0, "R6 single request for enable plus reset change",
            {31'b0, core_req[2]}, 0);
        rd_expect(0, cv & ~(32'h1 << 15), "R6 reset bit cleared after ack");

        tag = "R5";
        wr(0, m_regs[0] & ~(32'h1 << 22));
        chk(core_op[3:2] === 2'b10 && core_addr[63:32] === 32'h0, "R5 core1 stop op",
            {24'b0, core_op}, 32'h08);
        ack(1);

        tag = "R7";
        wr(0, m_regs[0] | (32'h1 << 13));
        chk(core_req[0] === 1'b1 && core_op[1:0] === 2'b11, "R7 core0 reset op",
            {24'b0, core_op}, 32'h03);
        ack(0);
        rd_expect(0, m_regs[0], "R7 core0 bit cleared");
        chk(rd_data[13] === 1'b0, "R7 core0 bit reads zero", rd_data, 0);
        wr(0, m_regs[0] | (32'h1 << 16));
        chk(core_op[7:6] === 2'b11, "R7 core3 reset op", {24'b0, core_op}, 32'hC0);
        cv = m_regs[0];
        core_ack[3] = 1'b1;
        acc_en = 1; acc_we = 1; acc_addr = 0; acc_wdata = cv;
        step();
        rd_expect(0, cv & ~(32'h1 << 16), "R7 ack beats same-cycle write");
        chk(core_req[3] === 1'b0, "R7 no new request after rewrite", {31'b0, core_req[3]}, 0);

        tag = "R8";
        cv = m_regs[0];
        wr(0, cv | (32'h1 << 3) | (32'h1 << 12));
        rd_expect(0, cv, "R8 display bits read back zero");
        chk(core_req === 4'b0, "R8 display reset raises no request", {28'b0, core_req}, 0);

        tag = "R9";
        wr(0, m_regs[0]);
        wr(0, m_regs[0] ^ 32'h0000_0020);
        chk(core_req === 4'b0, "R9 no request for unchanged action bits", {28'b0, core_req}, 0);

        tag = "R10";
        for (int k = 0; k < 5; k++) wr(0, m_regs[0] ^ (32'h1 << 13));
        for (int k = 0; k < QD; k++) begin
            chk(core_req[0] === 1'b1, "R10 queued request pending", {31'b0, core_req[0]}, 1);
            ack(0);
        end
        chk(core_req[0] === 1'b0, "R10 fifth request dropped when full",
            {31'b0, core_req[0]}, 0);
        rd_expect(0, m_regs[0], "R10 control after drain");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule